// File: doc/BRIEF.md
# Banked Memory Window Decoder

This block turns a 20-bit real-mode memory address into active-low chip selects for three targets:
- the main DRAM;
- a 128 KB display frame store;
- a 16 KB window into a paged flash disk.

An 8-bit page register supplies the flash address bits above the 16 KB window offset. Software writes that register over a small I/O path, and its top bit also lights a test LED. A separate I/O decode selects the display control registers.

Software can shrink the frame-store claim with a 2-bit range input so that only one 64 KB half answers as frame store. The other half then falls through to DRAM. With this, a full screen can be copied between frame store and RAM using block moves at the same addresses, one half at a time.

All memory selects are combinational from the address. They are gated by the memory-cycle strobe and by a read or write strobe, so no select moves outside a bus cycle. An access that no window covers drives no select and raises an unmapped flag.

Top module: `memwin_decoder`

## Requirements
- R1: During an active memory cycle (mem_cycle high and rd or wr high), an address below 0xC0000 that the frame store does not claim drives dram_sel_n low and no other select.
- R2: With fs_range = 2'b00, addresses 0xA0000 to 0xBFFFF drive fs_sel_n low and keep dram_sel_n high.
- R3: With fs_range = 2'b01, only 0xA0000 to 0xAFFFF select the frame store, and 0xB0000 to 0xBFFFF select DRAM.
- R4: With fs_range = 2'b10, only 0xB0000 to 0xBFFFF select the frame store, and 0xA0000 to 0xAFFFF select DRAM.
- R5: fs_range = 2'b11 decodes exactly like 2'b00 (full 128 KB frame store).
- R6: Addresses 0xC8000 to 0xCBFFF drive flash_sel_n low. 0xC7FFF and 0xCC000 do not.
- R7: The page register is 0 after a synchronous reset. On the clock after io_wr is high with io_addr = 0x0220, it holds io_wdata. A write to any other I/O address leaves it unchanged.
- R8: flash_page always shows the page register, and page_led equals its most significant bit.
- R9: Without an active memory cycle (mem_cycle low, or both rd and wr low), every memory select stays high and unmapped stays low.
- R10: An active cycle to 0xC0000 to 0xC7FFF or 0xCC000 to 0xFFFFF asserts no select and drives unmapped high.
- R11: disp_reg_sel_n is low when io_rd or io_wr is high and io_addr is in 0x0200 to 0x020F, and high otherwise.
- R12: At most one of dram_sel_n, fs_sel_n and flash_sel_n is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page register |
| rst | input | 1 | Synchronous active-high reset |
| mem_cycle | input | 1 | Memory (not I/O) bus cycle in progress |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 20 | Memory byte address |
| fs_range | input | 2 | Frame-store claim: 00 full, 01 low half, 10 high half, 11 full |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Low data byte for I/O writes |
| dram_sel_n | output | 1 | DRAM chip select, active low |
| fs_sel_n | output | 1 | Frame-store chip select, active low |
| flash_sel_n | output | 1 | Flash-disk window select, active low |
| flash_page | output | 8 | Upper flash address (page number) |
| page_led | output | 1 | Test LED, most significant page bit |
| disp_reg_sel_n | output | 1 | Display control register select, active low |
| unmapped | output | 1 | Active memory access that hit no window |

## Verification
The clocked checks sample the combinational selects at the rising edge. They therefore assume that address, strobes and fs_range are stable around that edge. The bench meets this by changing every input on the falling edge. The page-load property assumes that io_wdata is held for the edge on which io_wr is sampled, and the bench pulses io_wr for exactly one cycle with steady data. fs_range is assumed to change only between bus cycles. The vector table changes it only between entries, and each entry is evaluated by itself.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  typedef enum logic [1:0] {
    FS_FULL     = 2'b00,
    FS_LOW      = 2'b01,
    FS_HIGH     = 2'b10,
    FS_FULL_ALT = 2'b11
  } fs_range_e;

  localparam int unsigned MW_ADDR_W      = 20;
  localparam int unsigned MW_IO_W        = 16;
  localparam int unsigned MW_PAGE_W      = 8;
  localparam logic [19:0] MW_DRAM_LIMIT  = 20'hC0000;
  localparam logic [19:0] MW_FS_BASE     = 20'hA0000;
  localparam int unsigned MW_FS_SIZE     = 32'h20000;
  localparam logic [19:0] MW_FLASH_BASE  = 20'hC8000;
  localparam int unsigned MW_FLASH_SIZE  = 32'h4000;
  localparam logic [15:0] MW_DISP_IO     = 16'h0200;
  localparam int unsigned MW_DISP_IO_N   = 16;
  localparam logic [15:0] MW_PAGE_IO     = 16'h0220;

endpackage

// File: rtl/memwin_addr_window.sv
// Half-open range compare: hit when BASE <= a < BASE + SIZE.
module memwin_addr_window #(
  parameter int unsigned     W    = 20,
  parameter logic [W-1:0]    BASE = '0,
  parameter int unsigned     SIZE = 1
) (
  input  logic [W-1:0] a,
  output logic         hit
);
  localparam logic [W:0] HI = {1'b0, BASE} + (W+1)'(SIZE);

  generate
    if (BASE == '0) begin : g_zero_base
      assign hit = ({1'b0, a} < HI);
    end else begin : g_offset_base
      localparam logic [W:0] LO = {1'b0, BASE};
      assign hit = ({1'b0, a} >= LO) && ({1'b0, a} < HI);
    end
  endgenerate
endmodule

// File: rtl/memwin_fs_window.sv
// Frame-store claim with a selectable 64 KB half or the full window.
module memwin_fs_window
  import memwin_pkg::*;
#(
  parameter int unsigned        ADDR_W = 20,
  parameter logic [ADDR_W-1:0]  BASE   = 20'hA0000,
  parameter int unsigned        SIZE   = 32'h20000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        range_sel,
  output logic              hit
);
  localparam int unsigned HALF = SIZE / 2;

  logic [1:0] half_hit;

  for (genvar h = 0; h < 2; h++) begin : g_half
    memwin_addr_window #(
      .W    (ADDR_W),
      .BASE (BASE + ADDR_W'(h * HALF)),
      .SIZE (HALF)
    ) u_win (
      .a   (addr),
      .hit (half_hit[h])
    );
  end

  always_comb begin
    case (fs_range_e'(range_sel))
      FS_LOW:  hit = half_hit[0];
      FS_HIGH: hit = half_hit[1];
      default: hit = |half_hit;
    endcase
  end
endmodule

// File: rtl/memwin_page_latch.sv
// Flash page register, loaded by an I/O write to one port address.
module memwin_page_latch #(
  parameter int unsigned       IO_W       = 16,
  parameter int unsigned       PAGE_W     = 8,
  parameter logic [IO_W-1:0]   LATCH_ADDR = 16'h0220
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [IO_W-1:0]   io_addr,
  input  logic [PAGE_W-1:0] io_wdata,
  output logic [PAGE_W-1:0] page
);
  logic load;
  assign load = io_wr && (io_addr == LATCH_ADDR);

  always_ff @(posedge clk) begin
    if (rst)       page <= '0;
    else if (load) page <= io_wdata;
  end
endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter int unsigned         ADDR_W       = MW_ADDR_W,
  parameter int unsigned         IO_W         = MW_IO_W,
  parameter int unsigned         PAGE_W       = MW_PAGE_W,
  parameter logic [ADDR_W-1:0]   DRAM_LIMIT   = MW_DRAM_LIMIT,
  parameter logic [ADDR_W-1:0]   FS_BASE      = MW_FS_BASE,
  parameter int unsigned         FS_SIZE      = MW_FS_SIZE,
  parameter logic [ADDR_W-1:0]   FLASH_BASE   = MW_FLASH_BASE,
  parameter int unsigned         FLASH_SIZE   = MW_FLASH_SIZE,
  parameter logic [IO_W-1:0]     DISP_IO_BASE = MW_DISP_IO,
  parameter int unsigned         DISP_IO_N    = MW_DISP_IO_N,
  parameter logic [IO_W-1:0]     PAGE_IO_ADDR = MW_PAGE_IO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_cycle,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        fs_range,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [IO_W-1:0]   io_addr,
  input  logic [PAGE_W-1:0] io_wdata,
  output logic              dram_sel_n,
  output logic              fs_sel_n,
  output logic              flash_sel_n,
  output logic [PAGE_W-1:0] flash_page,
  output logic              page_led,
  output logic              disp_reg_sel_n,
  output logic              unmapped
);
  logic mem_act, io_act;
  logic dram_region, fs_hit, flash_hit, disp_hit;
  logic dram_hit;

  assign mem_act = mem_cycle && (rd || wr);
  assign io_act  = io_rd || io_wr;

  memwin_addr_window #(
    .W(ADDR_W), .BASE('0), .SIZE(int'(DRAM_LIMIT))
  ) u_dram_win (
    .a(addr), .hit(dram_region)
  );

  memwin_fs_window #(
    .ADDR_W(ADDR_W), .BASE(FS_BASE), .SIZE(FS_SIZE)
  ) u_fs_win (
    .addr(addr), .range_sel(fs_range), .hit(fs_hit)
  );

  memwin_addr_window #(
    .W(ADDR_W), .BASE(FLASH_BASE), .SIZE(FLASH_SIZE)
  ) u_flash_win (
    .a(addr), .hit(flash_hit)
  );

  memwin_addr_window #(
    .W(IO_W), .BASE(DISP_IO_BASE), .SIZE(DISP_IO_N)
  ) u_disp_win (
    .a(io_addr), .hit(disp_hit)
  );

  memwin_page_latch #(
    .IO_W(IO_W), .PAGE_W(PAGE_W), .LATCH_ADDR(PAGE_IO_ADDR)
  ) u_page (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .page(flash_page)
  );

  // Frame store wins inside the DRAM region; DRAM takes what it gives up.
  assign dram_hit = dram_region && !fs_hit;

  assign dram_sel_n     = !(mem_act && dram_hit);
  assign fs_sel_n       = !(mem_act && fs_hit);
  assign flash_sel_n    = !(mem_act && flash_hit);
  assign unmapped       = mem_act && !(dram_region || fs_hit || flash_hit);
  assign disp_reg_sel_n = !(io_act && disp_hit);
  assign page_led       = flash_page[PAGE_W-1];
endmodule

// File: rtl/memwin_decoder_chk.sv
module memwin_decoder_chk #(
  parameter int unsigned       ADDR_W       = 20,
  parameter int unsigned       IO_W         = 16,
  parameter int unsigned       PAGE_W       = 8,
  parameter logic [ADDR_W-1:0] DRAM_LIMIT   = 20'hC0000,
  parameter logic [ADDR_W-1:0] FS_LO        = 20'hA0000,
  parameter logic [ADDR_W-1:0] FS_HI        = 20'hBFFFF,
  parameter logic [ADDR_W-1:0] FLASH_LO     = 20'hC8000,
  parameter logic [ADDR_W-1:0] FLASH_HI     = 20'hCBFFF,
  parameter logic [IO_W-1:0]   PAGE_IO_ADDR = 16'h0220
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_cycle,
  input logic              rd,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic              io_wr,
  input logic [IO_W-1:0]   io_addr,
  input logic [PAGE_W-1:0] io_wdata,
  input logic              dram_sel_n,
  input logic              fs_sel_n,
  input logic              flash_sel_n,
  input logic [PAGE_W-1:0] flash_page,
  input logic              unmapped
);
  // R12
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!dram_sel_n, !fs_sel_n, !flash_sel_n}));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_cycle && (rd || wr)) |-> (dram_sel_n && fs_sel_n && flash_sel_n && !unmapped));

  // R10
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (dram_sel_n && fs_sel_n && flash_sel_n));

  // R1
  dram_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_sel_n |-> (addr < DRAM_LIMIT));

  // R2
  fs_inside_chk: assert property (@(posedge clk) disable iff (rst)
    !fs_sel_n |-> (addr >= FS_LO && addr <= FS_HI));

  // R6
  flash_inside_chk: assert property (@(posedge clk) disable iff (rst)
    !flash_sel_n |-> (addr >= FLASH_LO && addr <= FLASH_HI));

  // R7
  page_reset_chk: assert property (@(posedge clk)
    rst |=> (flash_page == '0));

  // R7
  page_load_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == PAGE_IO_ADDR) |=> (flash_page == $past(io_wdata)));

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr == PAGE_IO_ADDR) |=> $stable(flash_page));
endmodule

bind memwin_decoder memwin_decoder_chk u_chk (
  .clk(clk), .rst(rst), .mem_cycle(mem_cycle), .rd(rd), .wr(wr),
  .addr(addr), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
  .dram_sel_n(dram_sel_n), .fs_sel_n(fs_sel_n), .flash_sel_n(flash_sel_n),
  .flash_page(flash_page), .unmapped(unmapped)
);

// File: tb/memwin_decoder_bench.sv
module memwin_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_cycle = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [19:0] addr = '0;
  logic [1:0]  fs_range = 2'b00;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        dram_sel_n, fs_sel_n, flash_sel_n, page_led, disp_reg_sel_n, unmapped;
  logic [7:0]  flash_page;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  memwin_decoder u_memwin_decoder (
    .clk(clk), .rst(rst), .mem_cycle(mem_cycle), .rd(rd), .wr(wr),
    .addr(addr), .fs_range(fs_range), .io_rd(io_rd), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .dram_sel_n(dram_sel_n),
    .fs_sel_n(fs_sel_n), .flash_sel_n(flash_sel_n), .flash_page(flash_page),
    .page_led(page_led), .disp_reg_sel_n(disp_reg_sel_n), .unmapped(unmapped)
  );

  // {addr, fs_range, {mem_cycle,rd,wr}, expected {dram_n,fs_n,flash_n,unmapped}, req}
  localparam int NV = 22;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {20'h00000, 2'd0, 3'b110, 4'b0110, 4'd1},   // R1
    {20'h9FFFF, 2'd0, 3'b101, 4'b0110, 4'd1},   // R1
    {20'hA0000, 2'd0, 3'b110, 4'b1010, 4'd2},   // R2
    {20'hBFFFF, 2'd0, 3'b101, 4'b1010, 4'd2},   // R2
    {20'hA1234, 2'd1, 3'b110, 4'b1010, 4'd3},   // R3
    {20'hAFFFF, 2'd1, 3'b110, 4'b1010, 4'd3},   // R3
    {20'hB0000, 2'd1, 3'b101, 4'b0110, 4'd3},   // R3
    {20'hB8000, 2'd2, 3'b110, 4'b1010, 4'd4},   // R4
    {20'hAFFFF, 2'd2, 3'b110, 4'b0110, 4'd4},   // R4
    {20'hA0000, 2'd3, 3'b110, 4'b1010, 4'd5},   // R5
    {20'hBFFFF, 2'd3, 3'b101, 4'b1010, 4'd5},   // R5
    {20'hC8000, 2'd0, 3'b110, 4'b1100, 4'd6},   // R6
    {20'hCBFFF, 2'd0, 3'b101, 4'b1100, 4'd6},   // R6
    {20'hC7FFF, 2'd0, 3'b110, 4'b1111, 4'd10},  // R10 and R6 edge
    {20'hCC000, 2'd0, 3'b110, 4'b1111, 4'd10},  // R10 and R6 edge
    {20'hC0000, 2'd0, 3'b101, 4'b1111, 4'd10},  // R10
    {20'hFFFFF, 2'd0, 3'b110, 4'b1111, 4'd10},  // R10
    {20'h00000, 2'd0, 3'b010, 4'b1110, 4'd9},   // R9
    {20'hA0000, 2'd0, 3'b100, 4'b1110, 4'd9},   // R9
    {20'hC8000, 2'd0, 3'b011, 4'b1110, 4'd9},   // R9
    {20'hFFFFF, 2'd0, 3'b001, 4'b1110, 4'd9},   // R9
    {20'h12345, 2'd2, 3'b101, 4'b0110, 4'd1}    // R1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R7 reset value, R8 LED follows
    chk("R7", 32'(flash_page), 32'h0, "page after reset");
    chk("R8", 32'(page_led), 32'h0, "led after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i][32:13];
      fs_range = VEC[i][12:11];
      {mem_cycle, rd, wr} = VEC[i][10:8];
      #1;
      chk($sformatf("R%0d", VEC[i][3:0]),
          32'({dram_sel_n, fs_sel_n, flash_sel_n, unmapped}), 32'(VEC[i][7:4]),
          $sformatf("vector %0d selects", i));
      // R12 no two memory selects together
      chk("R12", 32'($countones({!dram_sel_n, !fs_sel_n, !flash_sel_n}) <= 1), 32'h1,
          $sformatf("vector %0d exclusivity", i));
    end
    @(negedge clk);
    mem_cycle = 1'b0; rd = 1'b0; wr = 1'b0; fs_range = 2'b00;

    // R7 load low byte, R8 LED clear
    io_write(16'h0220, 8'h5C);
    chk("R7", 32'(flash_page), 32'h5C, "page after load");
    chk("R8", 32'(page_led), 32'h0, "led with page 5C");
    // R7 other port ignored
    io_write(16'h0221, 8'hFF);
    chk("R7", 32'(flash_page), 32'h5C, "page after foreign write");
    io_write(16'h0200, 8'h33);
    chk("R7", 32'(flash_page), 32'h5C, "page after display-reg write");
    // R8 MSB drives LED
    io_write(16'h0220, 8'h80);
    chk("R8", 32'(flash_page), 32'h80, "page 80");
    chk("R8", 32'(page_led), 32'h1, "led with page 80");
    // R8 page stays visible during a flash access
    @(negedge clk);
    addr = 20'hC9000; mem_cycle = 1'b1; rd = 1'b1;
    #1;
    chk("R8", 32'({flash_sel_n, flash_page}), 32'h080, "flash access with page 80");
    mem_cycle = 1'b0; rd = 1'b0;

    // R11 display register decode
    @(negedge clk);
    io_addr = 16'h0200; io_rd = 1'b1; #1;
    chk("R11", 32'(disp_reg_sel_n), 32'h0, "io 0200 read");
    io_addr = 16'h020F; #1;
    chk("R11", 32'(disp_reg_sel_n), 32'h0, "io 020F read");
    io_addr = 16'h0210; #1;
    chk("R11", 32'(disp_reg_sel_n), 32'h1, "io 0210 read");
    io_addr = 16'h01FF; #1;
    chk("R11", 32'(disp_reg_sel_n), 32'h1, "io 01FF read");
    io_addr = 16'h0205; io_rd = 1'b0; #1;
    chk("R11", 32'(disp_reg_sel_n), 32'h1, "io 0205 no strobe");

    // R7 reset clears a loaded page
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; #1;
    chk("R7", 32'(flash_page), 32'h0, "page after second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule